// File: doc/BRIEF.md
# Frame-Aligned Stream Branch Gate

This block sits on one output of a stream fan-out whose input handshake completes only when every output has taken the beat. It lets one optional sink on that output, such as a frame-store writer, be turned off at run time without stalling the other outputs. While it is turned off, the gate accepts every upstream beat and forwards none. While it is turned on and aligned, it is a wire: no register, no buffering and no added cycle sits on the data path.

Turning the gate on never hands the sink a partial frame. After the enable rises, the gate keeps absorbing beats until a beat whose start-of-frame marker is set (bit 0 of the user sideband), and that beat is the first one forwarded. Turning it off is also clean. The frame in progress keeps flowing, and the next start-of-frame beat is absorbed and not sent. A build option ends forwarding at the next end-of-line beat instead. The enable passes through one register. That register freezes while a forwarded beat is stalled downstream, so a beat that has been offered is never withdrawn. A saturating counter reports how many frame starts were absorbed, and a two-bit status output shows the gate's mode.

Top module: `sof_branch_gate`

## Requirements
- R1: While reset (synchronous, active high) is applied and on the first cycle after it, the status output reads 0 (discard), the drop count reads 0 and `m_tvalid` is low.
- R2: In discard mode (status 0), `s_tready` is 1 whatever the level of `m_tready`, and `m_tvalid` is 0.
- R3: The enable is sampled by one register. A level placed on `en_i` before clock edge k is seen by the mode logic after edge k, so discard moves to wait-for-start (status 1) at edge k+1.
- R4: In wait-for-start mode, a beat with `s_tuser[0]` = 0 is absorbed (`s_tready` = 1, `m_tvalid` = 0). A beat with `s_tuser[0]` = 1 is forwarded, and its downstream acceptance moves the gate to forward mode (status 2).
- R5: In forward mode, apart from the absorbed start beat of R6, `s_tready` equals `m_tready`, `m_tvalid` equals `s_tvalid`, and `m_tdata`, `m_tuser`, `m_tlast` equal their upstream inputs in the same cycle.
- R6: With the default option (stop at frame end), a low registered enable in forward mode keeps forwarding until the next beat with `s_tuser[0]` = 1. That beat is absorbed, and the gate enters discard mode after that edge.
- R7: The drop count increases by one for each absorbed beat with `s_tuser[0]` = 1 and saturates at 2^CNT_W-1.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid` stays 1 and `m_tdata` stays stable on the next cycle, even if `en_i` changes. The enable register does not load on such a stalled edge.
- R9: The status output uses only the codes 0 (discard), 1 (wait-for-start) and 2 (forward).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable from a software-written control bit |
| s_tdata | input | DATA_W | Upstream beat data |
| s_tuser | input | USER_W | Upstream sideband, bit 0 marks start of frame |
| s_tlast | input | 1 | Upstream end-of-line marker |
| s_tvalid | input | 1 | Upstream beat valid |
| s_tready | output | 1 | Ready toward upstream |
| m_tdata | output | DATA_W | Downstream beat data |
| m_tuser | output | USER_W | Downstream sideband |
| m_tlast | output | 1 | Downstream end-of-line marker |
| m_tvalid | output | 1 | Downstream beat valid |
| m_tready | input | 1 | Ready from the sink |
| status_o | output | 2 | Mode: 0 discard, 1 wait-for-start, 2 forward |
| drop_cnt_o | output | CNT_W | Saturating count of absorbed frame starts |

## Verification
The bench raises the enable in mid-frame to check that no beat reaches the sink before a start-of-frame beat. A gate that forwarded at once would hand the sink a headless frame. It lowers the enable in mid-frame to check that the next start beat is absorbed and not forwarded. A gate that stopped at once would truncate a frame, and one that stopped late would leak a new frame head. It toggles the enable during downstream stalls, where a gate that reacted would withdraw `m_tvalid` in violation of the handshake. It runs many disabled frames with a sink that never gives ready, which would stall the shared fan-out if readiness were not faked, and it pushes the drop count past its ceiling to catch a counter that wraps.

// File: rtl/sof_gate_pkg.sv
package sof_gate_pkg;
   typedef enum logic [1:0] {
      GS_DISCARD = 2'd0,
      GS_WAIT    = 2'd1,
      GS_FWD     = 2'd2
   } gate_state_e;
endpackage

// File: rtl/gate_en_sync.sv
module gate_en_sync (
   input  logic clk,
   input  logic rst,
   input  logic en_i,
   input  logic stall_i,
   output logic en_q
);
   // R3/R8: single register, frozen while a forwarded beat waits downstream
   always_ff @(posedge clk) begin
      if (rst)           en_q <= 1'b0;
      else if (!stall_i) en_q <= en_i;
   end
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
   import sof_gate_pkg::*;
#(
   parameter bit STOP_ON_LINE_END = 1'b0
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        en_q,
   input  logic        s_valid,
   input  logic        s_sof,
   input  logic        s_last,
   input  logic        m_ready,
   output logic        pass_o,
   output gate_state_e state_o
);
   gate_state_e st, st_nx;
   logic        line_stop;

   // pass_o: present the current beat to the sink this cycle
   always_comb begin
      unique case (st)
         GS_FWD:  pass_o = !(!en_q && s_sof);
         GS_WAIT: pass_o = en_q && s_sof;
         default: pass_o = 1'b0;
      endcase
   end

   generate
      if (STOP_ON_LINE_END) begin : g_line_stop
         assign line_stop = !en_q && s_valid && m_ready && s_last;
      end else begin : g_frame_stop
         assign line_stop = 1'b0;
      end
   endgenerate

   always_comb begin
      st_nx = st;
      unique case (st)
         GS_DISCARD: if (en_q) st_nx = GS_WAIT;
         GS_WAIT: begin
            if (!en_q)                            st_nx = GS_DISCARD;
            else if (s_valid && s_sof && m_ready) st_nx = GS_FWD;
         end
         GS_FWD: begin
            if (!en_q && s_valid && s_sof) st_nx = GS_DISCARD;
            else if (line_stop)            st_nx = GS_DISCARD;
         end
         default: st_nx = GS_DISCARD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st <= GS_DISCARD;
      else     st <= st_nx;
   end

   assign state_o = st;
endmodule

// File: rtl/gate_drop_cnt.sv
module gate_drop_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bump_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (rst)                              count_o <= '0;
      else if (bump_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/sof_branch_gate.sv
module sof_branch_gate
   import sof_gate_pkg::*;
#(
   parameter int DATA_W           = 24,
   parameter int USER_W           = 1,
   parameter int CNT_W            = 8,
   parameter bit STOP_ON_LINE_END = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_i,
   input  logic [DATA_W-1:0] s_tdata,
   input  logic [USER_W-1:0] s_tuser,
   input  logic              s_tlast,
   input  logic              s_tvalid,
   output logic              s_tready,
   output logic [DATA_W-1:0] m_tdata,
   output logic [USER_W-1:0] m_tuser,
   output logic              m_tlast,
   output logic              m_tvalid,
   input  logic              m_tready,
   output logic [1:0]        status_o,
   output logic [CNT_W-1:0]  drop_cnt_o
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("sof_branch_gate: DATA_W must be at least 1");
      end
      if (USER_W < 1) begin : g_bad_user
         $error("sof_branch_gate: USER_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("sof_branch_gate: CNT_W must be 1..32");
      end
   endgenerate

   logic        en_q;
   logic        pass;
   logic        stall;
   gate_state_e st;

   assign stall = m_tvalid && !m_tready;

   gate_en_sync u_en (
      .clk     (clk),
      .rst     (rst),
      .en_i    (en_i),
      .stall_i (stall),
      .en_q    (en_q)
   );

   gate_ctrl #(.STOP_ON_LINE_END(STOP_ON_LINE_END)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .en_q    (en_q),
      .s_valid (s_tvalid),
      .s_sof   (s_tuser[0]),
      .s_last  (s_tlast),
      .m_ready (m_tready),
      .pass_o  (pass),
      .state_o (st)
   );

   gate_drop_cnt #(.CNT_W(CNT_W)) u_drop (
      .clk     (clk),
      .rst     (rst),
      .bump_i  (s_tvalid && !pass && s_tuser[0]),
      .count_o (drop_cnt_o)
   );

   assign s_tready = pass ? m_tready : 1'b1;
   assign m_tvalid = pass && s_tvalid;
   assign m_tdata  = s_tdata;
   assign m_tuser  = s_tuser;
   assign m_tlast  = s_tlast;
   assign status_o = st;
endmodule

// File: rtl/sof_branch_gate_chk.sv
module sof_branch_gate_chk #(
   parameter int DATA_W = 24,
   parameter int USER_W = 1,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] s_tdata,
   input logic [USER_W-1:0] s_tuser,
   input logic              s_tvalid,
   input logic              s_tready,
   input logic [DATA_W-1:0] m_tdata,
   input logic              m_tvalid,
   input logic              m_tready,
   input logic [1:0]        status_o,
   input logic [CNT_W-1:0]  drop_cnt_o
);
   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (status_o == 2'd0 && drop_cnt_o == '0 && !m_tvalid));

   p_discard_ready_r2: assert property (@(posedge clk) disable iff (rst)
      (status_o == 2'd0) |-> (s_tready && !m_tvalid));

   p_wait_sof_only_r4: assert property (@(posedge clk) disable iff (rst)
      (status_o == 2'd1 && m_tvalid) |-> s_tuser[0]);

   p_fwd_wire_r5: assert property (@(posedge clk) disable iff (rst)
      (status_o == 2'd2 && !s_tuser[0]) |->
         (s_tready == m_tready && m_tvalid == s_tvalid && m_tdata == s_tdata));

   p_drop_monotonic_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (drop_cnt_o >= $past(drop_cnt_o)));

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

   p_legal_code_r9: assert property (@(posedge clk) disable iff (rst)
      status_o != 2'd3);
endmodule

bind sof_branch_gate sof_branch_gate_chk #(
   .DATA_W (DATA_W),
   .USER_W (USER_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .s_tdata    (s_tdata),
   .s_tuser    (s_tuser),
   .s_tvalid   (s_tvalid),
   .s_tready   (s_tready),
   .m_tdata    (m_tdata),
   .m_tvalid   (m_tvalid),
   .m_tready   (m_tready),
   .status_o   (status_o),
   .drop_cnt_o (drop_cnt_o)
);

// File: tb/sof_branch_gate_test.sv
module sof_branch_gate_test;
   localparam int DW = 16;
   localparam int CW = 3;
   localparam int LINE_BEATS = 4;
   localparam int FRAME_BEATS = 12;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en_i = 1'b0;
   logic [DW-1:0] s_tdata;
   logic [0:0]    s_tuser;
   logic          s_tlast;
   logic          s_tvalid = 1'b0;
   logic          s_tready;
   logic [DW-1:0] m_tdata;
   logic [0:0]    m_tuser;
   logic          m_tlast;
   logic          m_tvalid;
   logic          m_tready = 1'b0;
   logic [1:0]    status_o;
   logic [CW-1:0] drop_cnt_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // source and reference state
   int            pos = 0;
   logic [DW-1:0] dcnt = '0;
   bit            acc_l = 0;
   int            ms = 0;
   bit            men = 0;
   logic [CW-1:0] mdrop = '0;
   bit            prev_stall = 0;
   logic [DW-1:0] prev_d = '0;

   always #2 clk = ~clk;

   sof_branch_gate #(.DATA_W(DW), .USER_W(1), .CNT_W(CW)) uut (
      .clk(clk), .rst(rst), .en_i(en_i),
      .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
      .s_tvalid(s_tvalid), .s_tready(s_tready),
      .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
      .m_tvalid(m_tvalid), .m_tready(m_tready),
      .status_o(status_o), .drop_cnt_o(drop_cnt_o)
   );

   assign s_tdata = dcnt;
   assign s_tuser = (pos == 0) ? 1'b1 : 1'b0;
   assign s_tlast = (pos % LINE_BEATS) == (LINE_BEATS - 1);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_pass(input int st, input bit en, input bit sof);
      if (st == 2) return !(!en && sof);
      if (st == 1) return en && sof;
      return 1'b0;
   endfunction

   function automatic string ready_tag(input int st);
      if (st == 0) return "R2 ready in discard";
      if (st == 1) return "R4 ready in wait";
      return "R5 ready in forward";
   endfunction

   // one clock: drive at negedge, check mid-cycle, advance model at posedge
   task automatic step(input bit want_v, input bit rdy, input bit en);
      bit ps, esr, emv, sof;
      @(negedge clk);
      if (acc_l) begin
         pos = (pos + 1) % FRAME_BEATS;
         dcnt = dcnt + 1'b1;
         s_tvalid = 1'b0;
      end
      if (!s_tvalid) s_tvalid = want_v;
      m_tready = rdy;
      en_i = en;
      #1;
      sof = (pos == 0);
      ps  = exp_pass(ms, men, sof);
      esr = ps ? m_tready : 1'b1;
      emv = ps && s_tvalid;
      chk(s_tready == esr, ready_tag(ms), s_tready, esr);
      chk(m_tvalid == emv, (ms == 1) ? "R4 valid in wait" : (ms == 2) ? "R6 valid in forward" : "R2 valid in discard", m_tvalid, emv);
      if (emv) chk(m_tdata == s_tdata && m_tuser == s_tuser && m_tlast == s_tlast, "R5 data path", m_tdata, s_tdata);
      chk(status_o == ms[1:0], "R9 R3 status", status_o, ms);
      chk(drop_cnt_o == mdrop, "R7 drop count", drop_cnt_o, mdrop);
      if (prev_stall) chk(m_tvalid && m_tdata == prev_d, "R8 stall hold", m_tdata, prev_d);
      prev_stall = emv && !m_tready;
      prev_d = m_tdata;
      @(posedge clk);
      acc_l = s_tvalid && esr;
      if (s_tvalid && !ps && sof && mdrop != CMAX) mdrop = mdrop + 1'b1;
      case (ms)
         0: if (men) ms = 1;
         1: if (!men) ms = 0; else if (s_tvalid && sof && m_tready) ms = 2;
         default: if (!men && s_tvalid && sof) ms = 0;
      endcase
      if (!(emv && !m_tready)) men = en;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      // R1: reset
      s_tvalid = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(status_o == 2'd0, "R1 status in reset", status_o, 0);
      chk(m_tvalid == 1'b0, "R1 valid in reset", m_tvalid, 0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(drop_cnt_o == '0, "R1 drop after reset", drop_cnt_o, 0);
      chk(status_o == 2'd0 && !m_tvalid, "R1 first cycle", status_o, 0);
      s_tvalid = 1'b0;
      pos = 5;
      // R2: disabled, sink never ready
      for (int i = 0; i < 30; i++) step($urandom_range(0, 1), 1'b0, 1'b0);
      // R3/R4: enable rises mid-frame
      for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1);
      chk(ms == 2, "R4 reached forward", status_o, 2);
      // R6: enable falls mid-frame
      while (pos != 6) step(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0);
      chk(status_o == 2'd0, "R6 discard after frame end", status_o, 0);
      // R8: stall while toggling enable
      for (int i = 0; i < 30; i++) step(1'b1, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) step(1'b1, 1'b0, i[0]);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1);
      // random traffic
      begin
         bit en_r = 1'b1;
         for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 59) == 0) en_r = !en_r;
            step($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 7, en_r);
         end
      end
      // R7: saturation of the drop count
      for (int i = 0; i < 200; i++) step(1'b1, $urandom_range(0, 1), 1'b0);
      step(1'b0, 1'b0, 1'b0);
      chk(drop_cnt_o == CMAX, "R7 saturated", drop_cnt_o, CMAX);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule